// File: doc/BRIEF.md
# Byte-Mapped Audio Frame Demultiplexer

This block takes a multichannel audio frame that arrives as a series of 32-bit sample words and spreads its bytes across four outgoing word streams. Routing is set per byte rather than per channel. Every byte position of the incoming frame owns an enable bit and an 8-bit routing entry. The entry picks the destination stream, the channel (word) inside that stream, and the byte lane inside that word. Any input byte can therefore land anywhere in any of the four outputs. Typical uses are splitting a wide time-slot frame into separate device streams, or reordering and repacking sample bytes.

Incoming words are placed into a per-stream staging buffer as they arrive. When the last word of the frame has been taken in, the enabled streams are sent out one word per cycle. Streams go in ascending order, and each stream's channels go in ascending order, with a last flag on the highest channel. The routing table, the stream settings and the frame length are written through a small write port. Each write goes into a shadow copy, and the shadow becomes active only when the next frame start is sampled.

Top module: `frame_byte_router`

## Requirements
- R1: An enabled input byte position p goes to one place only. That place is stream entry[7:6], channel entry[5:2], byte lane entry[1:0], where the lane covers output bits [8*lane+7 : 8*lane]. Position p is taken from bits [8*(p mod 4)+7 : 8*(p mod 4)] of input word p div 4, where word 0 is the word flagged with the frame start. A slot is written at address p (0..63) with wdata[8] as its enable and wdata[7:0] as its entry.
- R2: An output byte lane that no enabled position of the current frame targets is zero. A position whose enable is clear is routed nowhere. No byte carries over from an earlier frame.
- R3: Emission begins after the frame's last input word. Enabled streams are sent in ascending stream number. Each stream sends channels 0..N-1 on consecutive cycles, with out_last raised only with channel N-1. At most one out_valid bit is high in any cycle, and out_data is zero outside valid cycles.
- R4: A stream is configured at address 64+s, and wdata[8] is its enable. A disabled stream never asserts out_valid, even when enabled positions target it.
- R5: wdata[3:0] at address 64+s holds the channel count minus one, so each stream carries 1 to 16 channels.
- R6: Address 68, wdata[3:0], holds the frame length minus one, in input words (1 to 16). The first output word is valid two clock edges after the edge that samples the frame's last input word.
- R7: Writes to any address take effect only when the next frame start is sampled. A write on the same edge as a frame start applies to the frame after it.
- R8: Input words with in_valid high are ignored while no frame is open. This covers words before any frame start and words after the frame's last word. Such words produce no output.
- R9: When two enabled positions target the same lane of the same channel, the higher position number wins.
- R10: After reset no output is valid and all slots and streams are disabled, so a frame sent with the reset settings produces no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 7 | Write address: slot 0..63, stream 64..67, frame length 68 |
| cfg_wdata | input | 9 | Write data: enable in bit 8, value below it |
| in_valid | input | 1 | Input word valid |
| in_sof | input | 1 | Marks the first word of a frame |
| in_data | input | 32 | Input sample word |
| out_valid | output | 4 | Per-stream word valid |
| out_last | output | 4 | Per-stream last channel of frame |
| out_data | output | 128 | Stream s word in bits [32*s+31 : 32*s] |

## Verification
The bench targets byte positions at the edges of the frame: the first and last byte, and bytes that land in channel 15 or lane 3. A decode that swapped the stream, channel or lane fields, or mixed up the byte-to-word order, would put a known nonzero byte in the wrong lane. It also drives two positions onto one lane, which exposes the wrong priority, and it follows a rich frame with a sparse one, so a staging buffer that is not cleared leaks stale bytes. Configuration writes are issued on the frame-start edge and in mid-frame. A design that applied them at once would change the channel count or routing of the frame already in flight. Stray words outside a frame, and words beyond the programmed length, would start a spurious emission or corrupt data in a design that did not track frame state.

// File: rtl/fbr_pkg.sv
package fbr_pkg;
   localparam int unsigned DEF_OUTS     = 4;
   localparam int unsigned DEF_MAX_CH   = 16;
   localparam int unsigned DEF_IN_WORDS = 16;
   localparam int unsigned DEF_WORD_W   = 32;

   typedef enum logic {EM_IDLE = 1'b0, EM_RUN = 1'b1} em_state_t;
endpackage

// File: rtl/fbr_cfg_bank.sv
module fbr_cfg_bank #(
   parameter int unsigned NUM_OUT  = fbr_pkg::DEF_OUTS,
   parameter int unsigned MAX_CH   = fbr_pkg::DEF_MAX_CH,
   parameter int unsigned IN_WORDS = fbr_pkg::DEF_IN_WORDS,
   parameter int unsigned WORD_W   = fbr_pkg::DEF_WORD_W,
   localparam int unsigned LANES     = WORD_W / 8,
   localparam int unsigned LANE_W    = $clog2(LANES),
   localparam int unsigned NUM_SLOTS = IN_WORDS * LANES,
   localparam int unsigned STREAM_W  = $clog2(NUM_OUT),
   localparam int unsigned CH_W      = $clog2(MAX_CH),
   localparam int unsigned IW_W      = $clog2(IN_WORDS),
   localparam int unsigned ENT_W     = STREAM_W + CH_W + LANE_W,
   localparam int unsigned ADDR_W    = $clog2(NUM_SLOTS + NUM_OUT + 1)
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic                                cfg_we,
   input  logic [ADDR_W-1:0]                   cfg_addr,
   input  logic [ENT_W:0]                      cfg_wdata,
   input  logic                                commit,
   output logic [NUM_SLOTS-1:0]                act_en,
   output logic [NUM_SLOTS-1:0][ENT_W-1:0]     act_map,
   output logic [NUM_OUT-1:0]                  act_sen,
   output logic [NUM_OUT-1:0][CH_W-1:0]        act_cnt,
   output logic [IW_W-1:0]                     act_inw
);
   localparam int unsigned SLOT_AW = $clog2(NUM_SLOTS);

   logic [NUM_SLOTS-1:0]            sh_en;
   logic [NUM_SLOTS-1:0][ENT_W-1:0] sh_map;
   logic [NUM_OUT-1:0]              sh_sen;
   logic [NUM_OUT-1:0][CH_W-1:0]    sh_cnt;
   logic [IW_W-1:0]                 sh_inw;
   logic [ADDR_W-1:0]               soff;
   logic [SLOT_AW-1:0]              slot_idx;
   logic [STREAM_W-1:0]             str_idx;
   logic                            wbit;

   assign soff     = cfg_addr - ADDR_W'(NUM_SLOTS);
   assign slot_idx = cfg_addr[SLOT_AW-1:0];
   assign str_idx  = soff[STREAM_W-1:0];
   assign wbit     = cfg_wdata[ENT_W];

   // shadow copy, written at any time
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_en  <= '0;
         sh_map <= '0;
         sh_sen <= '0;
         sh_cnt <= '0;
         sh_inw <= '1;
      end else if (cfg_we) begin
         if (cfg_addr < ADDR_W'(NUM_SLOTS)) begin
            sh_en[slot_idx]  <= wbit;
            sh_map[slot_idx] <= wbit ? cfg_wdata[ENT_W-1:0] : '0;
         end else if (cfg_addr < ADDR_W'(NUM_SLOTS + NUM_OUT)) begin
            sh_sen[str_idx] <= wbit;
            sh_cnt[str_idx] <= cfg_wdata[CH_W-1:0];
         end else if (cfg_addr == ADDR_W'(NUM_SLOTS + NUM_OUT)) begin
            sh_inw <= cfg_wdata[IW_W-1:0];
         end
      end
   end

   // active copy, refreshed only on a sampled frame start
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_en  <= '0;
         act_map <= '0;
         act_sen <= '0;
         act_cnt <= '0;
         act_inw <= '1;
      end else if (commit) begin
         act_en  <= sh_en;
         act_map <= sh_map;
         act_sen <= sh_sen;
         act_cnt <= sh_cnt;
         act_inw <= sh_inw;
      end
   end

   a_r7_hold_between_frames: assert property (@(posedge clk) disable iff (!rst_n)
      !commit |=> ($stable(act_en) && $stable(act_map) && $stable(act_sen)
                   && $stable(act_cnt) && $stable(act_inw)));
endmodule

// File: rtl/fbr_stager.sv
module fbr_stager #(
   parameter int unsigned NUM_OUT  = fbr_pkg::DEF_OUTS,
   parameter int unsigned MAX_CH   = fbr_pkg::DEF_MAX_CH,
   parameter int unsigned IN_WORDS = fbr_pkg::DEF_IN_WORDS,
   parameter int unsigned WORD_W   = fbr_pkg::DEF_WORD_W,
   localparam int unsigned LANES     = WORD_W / 8,
   localparam int unsigned LANE_W    = $clog2(LANES),
   localparam int unsigned NUM_SLOTS = IN_WORDS * LANES,
   localparam int unsigned STREAM_W  = $clog2(NUM_OUT),
   localparam int unsigned CH_W      = $clog2(MAX_CH),
   localparam int unsigned IW_W      = $clog2(IN_WORDS),
   localparam int unsigned ENT_W     = STREAM_W + CH_W + LANE_W
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            in_valid,
   input  logic                            in_sof,
   input  logic [WORD_W-1:0]               in_data,
   input  logic [NUM_SLOTS-1:0]            act_en,
   input  logic [NUM_SLOTS-1:0][ENT_W-1:0] act_map,
   input  logic [IW_W-1:0]                 act_inw,
   input  logic [STREAM_W-1:0]             rd_s,
   input  logic [CH_W-1:0]                 rd_c,
   output logic [WORD_W-1:0]               rd_word,
   output logic                            frame_end
);
   localparam int unsigned SLOT_AW = IW_W + LANE_W;

   logic                p_valid, p_sof;
   logic [WORD_W-1:0]   p_data;
   logic [IW_W-1:0]     wcnt, wi;
   logic                in_frame, accept;
   logic [WORD_W-1:0]   stg [NUM_OUT][MAX_CH];

   logic [LANES-1:0]                 hit;
   logic [LANES-1:0][STREAM_W-1:0]   dst_s;
   logic [LANES-1:0][CH_W-1:0]       dst_c;
   logic [LANES-1:0][LANE_W-1:0]     dst_l;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         p_valid <= 1'b0;
         p_sof   <= 1'b0;
         p_data  <= '0;
      end else begin
         p_valid <= in_valid;
         p_sof   <= in_valid & in_sof;
         p_data  <= in_data;
      end
   end

   assign accept    = p_valid & (p_sof | in_frame);
   assign wi        = p_sof ? '0 : wcnt;
   assign frame_end = accept & (wi == act_inw);

   // per-lane decode of the routing entry for the word being staged
   for (genvar b = 0; b < LANES; b++) begin : g_lane
      localparam logic [LANE_W-1:0] BL = LANE_W'(b);
      logic [SLOT_AW-1:0] slot;
      assign slot     = {wi, BL};
      assign hit[b]   = act_en[slot];
      assign dst_s[b] = act_map[slot][ENT_W-1 -: STREAM_W];
      assign dst_c[b] = act_map[slot][LANE_W +: CH_W];
      assign dst_l[b] = act_map[slot][LANE_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wcnt     <= '0;
         in_frame <= 1'b0;
      end else if (accept) begin
         wcnt     <= wi + 1'b1;
         in_frame <= (wi != act_inw);
      end
   end

   // staging buffer: cleared by the frame start word, later lanes override earlier
   always_ff @(posedge clk) begin
      if (accept) begin
         if (p_sof) begin
            for (int s = 0; s < NUM_OUT; s++)
               for (int c = 0; c < MAX_CH; c++)
                  stg[s][c] <= '0;
         end
         for (int b = 0; b < LANES; b++)
            if (hit[b])
               stg[dst_s[b]][dst_c[b]][8*dst_l[b] +: 8] <= p_data[8*b +: 8];
      end
   end

   assign rd_word = stg[rd_s][rd_c];

   a_r6_frame_closes: assert property (@(posedge clk) disable iff (!rst_n)
      frame_end |=> !in_frame);
   a_r8_stray_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (p_valid && !p_sof && !in_frame) |=> (!in_frame && $stable(wcnt)));
endmodule

// File: rtl/fbr_emitter.sv
module fbr_emitter #(
   parameter int unsigned NUM_OUT = fbr_pkg::DEF_OUTS,
   parameter int unsigned MAX_CH  = fbr_pkg::DEF_MAX_CH,
   parameter int unsigned WORD_W  = fbr_pkg::DEF_WORD_W,
   localparam int unsigned STREAM_W = $clog2(NUM_OUT),
   localparam int unsigned CH_W     = $clog2(MAX_CH)
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         start,
   input  logic [NUM_OUT-1:0]           act_sen,
   input  logic [NUM_OUT-1:0][CH_W-1:0] act_cnt,
   output logic [STREAM_W-1:0]          rd_s,
   output logic [CH_W-1:0]              rd_c,
   input  logic [WORD_W-1:0]            rd_word,
   output logic [NUM_OUT-1:0]           out_valid,
   output logic [NUM_OUT-1:0]           out_last,
   output logic [WORD_W-1:0]            out_word
);
   import fbr_pkg::*;

   em_state_t           st;
   logic [STREAM_W-1:0] s_cur, first_s, next_s;
   logic [CH_W-1:0]     c_cur;
   logic                first_ok, next_ok, at_end;

   always_comb begin
      first_ok = 1'b0;
      first_s  = '0;
      next_ok  = 1'b0;
      next_s   = '0;
      for (int s = NUM_OUT - 1; s >= 0; s--) begin
         if (act_sen[s]) begin
            first_ok = 1'b1;
            first_s  = STREAM_W'(s);
            if (s > int'(s_cur)) begin
               next_ok = 1'b1;
               next_s  = STREAM_W'(s);
            end
         end
      end
   end

   assign at_end = (c_cur == act_cnt[s_cur]);
   assign rd_s   = s_cur;
   assign rd_c   = c_cur;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= EM_IDLE;
         s_cur     <= '0;
         c_cur     <= '0;
         out_valid <= '0;
         out_last  <= '0;
         out_word  <= '0;
      end else begin
         out_valid <= '0;
         out_last  <= '0;
         if (st == EM_RUN) begin
            out_word         <= rd_word;
            out_valid[s_cur] <= 1'b1;
            out_last[s_cur]  <= at_end;
            if (at_end) begin
               if (next_ok) begin
                  s_cur <= next_s;
                  c_cur <= '0;
               end else begin
                  st <= EM_IDLE;
               end
            end else begin
               c_cur <= c_cur + 1'b1;
            end
         end else if (start && first_ok) begin
            st    <= EM_RUN;
            s_cur <= first_s;
            c_cur <= '0;
         end
      end
   end

   a_r3_single_stream: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(out_valid));
   a_r3_run_continues: assert property (@(posedge clk) disable iff (!rst_n)
      (|(out_valid & ~out_last)) |=> (out_valid == $past(out_valid)));
   a_r4_only_enabled: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid & ~act_sen) == '0);
   a_r6_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> (st == EM_IDLE));
endmodule

// File: rtl/frame_byte_router.sv
module frame_byte_router #(
   parameter int unsigned NUM_OUT  = fbr_pkg::DEF_OUTS,
   parameter int unsigned MAX_CH   = fbr_pkg::DEF_MAX_CH,
   parameter int unsigned IN_WORDS = fbr_pkg::DEF_IN_WORDS,
   parameter int unsigned WORD_W   = fbr_pkg::DEF_WORD_W
) (
   input  logic                                                     clk,
   input  logic                                                     rst_n,
   input  logic                                                     cfg_we,
   input  logic [$clog2(IN_WORDS*(WORD_W/8)+NUM_OUT+1)-1:0]         cfg_addr,
   input  logic [$clog2(NUM_OUT)+$clog2(MAX_CH)+$clog2(WORD_W/8):0] cfg_wdata,
   input  logic                                                     in_valid,
   input  logic                                                     in_sof,
   input  logic [WORD_W-1:0]                                        in_data,
   output logic [NUM_OUT-1:0]                                       out_valid,
   output logic [NUM_OUT-1:0]                                       out_last,
   output logic [NUM_OUT*WORD_W-1:0]                                out_data
);
   localparam int unsigned LANES     = WORD_W / 8;
   localparam int unsigned LANE_W    = $clog2(LANES);
   localparam int unsigned NUM_SLOTS = IN_WORDS * LANES;
   localparam int unsigned STREAM_W  = $clog2(NUM_OUT);
   localparam int unsigned CH_W      = $clog2(MAX_CH);
   localparam int unsigned IW_W      = $clog2(IN_WORDS);
   localparam int unsigned ENT_W     = STREAM_W + CH_W + LANE_W;

   // elaboration-time parameter checks
   if (NUM_OUT < 2 || (NUM_OUT & (NUM_OUT - 1)) != 0) begin : g_bad_outs
      $error("NUM_OUT must be a power of two, at least 2");
   end
   if (MAX_CH < 2 || (MAX_CH & (MAX_CH - 1)) != 0) begin : g_bad_ch
      $error("MAX_CH must be a power of two, at least 2");
   end
   if (IN_WORDS < 2 || (IN_WORDS & (IN_WORDS - 1)) != 0) begin : g_bad_words
      $error("IN_WORDS must be a power of two, at least 2");
   end
   if (WORD_W % 8 != 0 || LANES < 2 || (LANES & (LANES - 1)) != 0) begin : g_bad_width
      $error("WORD_W must hold a power-of-two count of bytes, at least 2");
   end
   if (ENT_W < IW_W) begin : g_bad_ent
      $error("routing entry narrower than the frame length field");
   end

   logic [NUM_SLOTS-1:0]            act_en;
   logic [NUM_SLOTS-1:0][ENT_W-1:0] act_map;
   logic [NUM_OUT-1:0]              act_sen;
   logic [NUM_OUT-1:0][CH_W-1:0]    act_cnt;
   logic [IW_W-1:0]                 act_inw;
   logic [STREAM_W-1:0]             rd_s;
   logic [CH_W-1:0]                 rd_c;
   logic [WORD_W-1:0]               rd_word, out_word;
   logic                            frame_end;

   fbr_cfg_bank #(.NUM_OUT(NUM_OUT), .MAX_CH(MAX_CH), .IN_WORDS(IN_WORDS), .WORD_W(WORD_W)) u_cfg (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
      .commit(in_valid & in_sof), .act_en(act_en), .act_map(act_map),
      .act_sen(act_sen), .act_cnt(act_cnt), .act_inw(act_inw));

   fbr_stager #(.NUM_OUT(NUM_OUT), .MAX_CH(MAX_CH), .IN_WORDS(IN_WORDS), .WORD_W(WORD_W)) u_stg (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof), .in_data(in_data),
      .act_en(act_en), .act_map(act_map), .act_inw(act_inw),
      .rd_s(rd_s), .rd_c(rd_c), .rd_word(rd_word), .frame_end(frame_end));

   fbr_emitter #(.NUM_OUT(NUM_OUT), .MAX_CH(MAX_CH), .WORD_W(WORD_W)) u_emit (
      .clk(clk), .rst_n(rst_n), .start(frame_end), .act_sen(act_sen), .act_cnt(act_cnt),
      .rd_s(rd_s), .rd_c(rd_c), .rd_word(rd_word),
      .out_valid(out_valid), .out_last(out_last), .out_word(out_word));

   for (genvar s = 0; s < NUM_OUT; s++) begin : g_out
      assign out_data[s*WORD_W +: WORD_W] = out_valid[s] ? out_word : '0;
   end
endmodule

// File: tb/sim_frame_byte_router.sv
`timescale 1ns/1ps
module sim_frame_byte_router;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [6:0]  cfg_addr = '0;
   logic [8:0]  cfg_wdata = '0;
   logic        in_valid = 1'b0;
   logic        in_sof = 1'b0;
   logic [31:0] in_data = '0;
   logic [3:0]  out_valid, out_last;
   logic [127:0] out_data;

   always #2.5 clk = ~clk;

   frame_byte_router u0 (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
      .in_valid(in_valid), .in_sof(in_sof), .in_data(in_data),
      .out_valid(out_valid), .out_last(out_last), .out_data(out_data));

   int checks = 0, errors = 0, cyc = 0, last_cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   // mirror of written configuration and snapshot used for a frame
   logic       m_en [64];  logic [7:0] m_map [64];
   logic       m_sen [4];  int m_cnt [4];  int m_inw;
   logic       c_en [64];  logic [7:0] c_map [64];
   logic       c_sen [4];  int c_cnt [4];  int c_inw;
   logic [31:0] fr [16];

   int lg_n = 0;
   int lg_s [512]; logic [31:0] lg_d [512]; logic lg_l [512]; int lg_cyc [512];

   always @(negedge clk) begin
      for (int s = 0; s < 4; s++) begin
         if (out_valid[s] && lg_n < 512) begin
            lg_s[lg_n] = s; lg_d[lg_n] = out_data[s*32 +: 32];
            lg_l[lg_n] = out_last[s]; lg_cyc[lg_n] = cyc;
            lg_n = lg_n + 1;
         end
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   task automatic wr(input int a, input int d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = 7'(a); cfg_wdata = 9'(d);
      if (a < 64) begin
         m_en[a] = d[8]; m_map[a] = d[8] ? 8'(d) : 8'h00;
      end else if (a < 68) begin
         m_sen[a-64] = d[8]; m_cnt[a-64] = d & 15;
      end else if (a == 68) m_inw = d & 15;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic set_stream(input int s, input bit en, input int cnt);
      wr(64 + s, (int'(en) << 8) | ((cnt - 1) & 15));
   endtask

   task automatic snap();
      for (int p = 0; p < 64; p++) begin c_en[p] = m_en[p]; c_map[p] = m_map[p]; end
      for (int s = 0; s < 4; s++) begin c_sen[s] = m_sen[s]; c_cnt[s] = m_cnt[s]; end
      c_inw = m_inw;
   endtask

   task automatic send(input int n, input bit with_sof);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_valid = 1'b1; in_sof = with_sof && (i == 0); in_data = fr[i];
      end
      @(posedge clk); #1 last_cyc = cyc;
      @(negedge clk);
      in_valid = 1'b0; in_sof = 1'b0;
   endtask

   function automatic logic [7:0] pbyte(input int p, input int seed);
      return 8'(((p * 37 + seed * 11) % 255) + 1);
   endfunction

   task automatic fill(input int seed);
      for (int w = 0; w < 16; w++)
         for (int b = 0; b < 4; b++) fr[w][8*b +: 8] = pbyte(4*w + b, seed);
   endtask

   // expected emission computed from the requirements
   task automatic expect_frame(input string req);
      logic [31:0] ex [4][16];
      int idx;
      for (int s = 0; s < 4; s++) for (int c = 0; c < 16; c++) ex[s][c] = '0;
      for (int p = 0; p < (c_inw + 1) * 4; p++)
         if (c_en[p]) ex[c_map[p][7:6]][c_map[p][5:2]][8*c_map[p][1:0] +: 8] = fr[p/4][8*(p%4) +: 8];
      idx = 0;
      for (int s = 0; s < 4; s++) begin
         if (c_sen[s]) begin
            for (int c = 0; c <= c_cnt[s]; c++) begin
               if (idx < lg_n) begin
                  chk(lg_s[idx] == s, req, "stream order", lg_s[idx], s);
                  chk(lg_d[idx] == ex[s][c], req, "word data", lg_d[idx], ex[s][c]);
                  chk(lg_l[idx] == (c == c_cnt[s]), req, "last flag", lg_l[idx], (c == c_cnt[s]));
               end
               idx++;
            end
         end
      end
      chk(lg_n == idx, req, "word count", lg_n, idx);
   endtask

   task automatic run_frame(input int n, input string req);
      lg_n = 0; snap(); send(n, 1'b1);
      repeat (90) @(negedge clk);
      expect_frame(req);
   endtask

   // R1 routing vectors: {byte position, entry}
   localparam logic [13:0] VEC [8] = '{
      {6'd0, 8'h00}, {6'd7, 8'h4E}, {6'd13, 8'hBD}, {6'd22, 8'hE3},
      {6'd31, 8'h25}, {6'd40, 8'h43}, {6'd58, 8'h98}, {6'd63, 8'hFE}};

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      for (int p = 0; p < 64; p++) begin m_en[p] = 0; m_map[p] = 0; end
      for (int s = 0; s < 4; s++) begin m_sen[s] = 0; m_cnt[s] = 0; end
      m_inw = 15;
      repeat (3) @(negedge clk);
      // R10 reset state
      chk(out_valid == 4'h0, "R10", "valid after reset", out_valid, 0);
      chk(out_last == 4'h0, "R10", "last after reset", out_last, 0);
      chk(out_data == '0, "R10", "data after reset", out_data[31:0], 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      fill(1);
      run_frame(16, "R10");

      // R1 table walk: one slot at a time, all streams at 16 channels
      for (int s = 0; s < 4; s++) set_stream(s, 1'b1, 16);
      for (int r = 0; r < 8; r++) begin
         if (r > 0) wr(int'(VEC[r-1][13:8]), 0);
         wr(int'(VEC[r][13:8]), 256 | int'(VEC[r][7:0]));
         fill(r + 3);
         run_frame(16, "R1");
      end
      wr(int'(VEC[7][13:8]), 0);

      // R2 rich frame then sparse frame, no carry-over
      for (int s = 0; s < 4; s++) set_stream(s, s == 0, 2);
      for (int p = 0; p < 8; p++) wr(p, 256 | ((p / 4) << 2) | (p % 4));
      fill(20); run_frame(16, "R2");
      for (int p = 1; p < 8; p++) wr(p, 0);
      fill(21); run_frame(16, "R2");

      // R3 R4 R5 order across streams, disabled stream, counts 1 and 16
      set_stream(0, 1'b0, 1); set_stream(1, 1'b1, 1); set_stream(2, 1'b0, 4); set_stream(3, 1'b1, 16);
      wr(0, 256 | 8'h00);                 // to disabled stream 0
      wr(1, 256 | 8'h42);                 // stream 1 ch0 lane2
      wr(2, 256 | 8'h85);                 // stream 2 (disabled) ch1 lane1
      wr(9, 256 | 8'hFF);                 // stream 3 ch15 lane3
      wr(12, 256 | 8'hC0);                // stream 3 ch0 lane0
      fill(30); run_frame(16, "R3");
      chk(lg_n == 17, "R4", "words from two enabled streams", lg_n, 17);
      chk(lg_n > 16 && lg_s[16] == 3 && lg_l[16], "R5", "sixteenth channel is last", lg_n > 16 ? lg_s[16] : -1, 3);

      // R6 frame length 2 with extra words, latency two edges
      wr(68, 1);
      fill(40); run_frame(4, "R6");
      chk(lg_n > 0 && lg_cyc[0] == last_cyc - 2 + 2, "R6", "first output cycle", lg_n > 0 ? lg_cyc[0] : -1, last_cyc);
      lg_n = 0; snap(); send(2, 1'b1); repeat (40) @(negedge clk);
      chk(lg_n > 0 && lg_cyc[0] == last_cyc + 2, "R6", "latency after last word", lg_n > 0 ? lg_cyc[0] - last_cyc : -1, 2);
      expect_frame("R6");

      // R8 stray words with no frame open
      lg_n = 0; fill(41); send(3, 1'b0); repeat (30) @(negedge clk);
      chk(lg_n == 0, "R8", "output from stray words", lg_n, 0);

      // R9 collision: positions 1 and 2 to the same lane, 3 and 4 across words
      set_stream(1, 1'b0, 1); set_stream(3, 1'b0, 1); set_stream(0, 1'b1, 1);
      for (int p = 0; p < 16; p++) wr(p, 0);
      wr(1, 256 | 8'h03); wr(2, 256 | 8'h03); wr(3, 256 | 8'h00); wr(4, 256 | 8'h00);
      fill(50); run_frame(2, "R9");
      chk(lg_n > 0 && lg_d[0] == {fr[0][23:16], 16'h0, fr[1][7:0]}, "R9", "higher position wins",
          lg_n > 0 ? lg_d[0] : 0, {fr[0][23:16], 16'h0, fr[1][7:0]});

      // R7 write on the frame start edge lands one frame later
      lg_n = 0; snap(); fill(60);
      fork
         send(2, 1'b1);
         set_stream(0, 1'b1, 4);
      join
      repeat (40) @(negedge clk);
      expect_frame("R7");
      chk(lg_n == 1, "R7", "count unchanged in flight", lg_n, 1);
      // mid-frame write also deferred
      lg_n = 0; snap(); fill(61);
      fork
         send(2, 1'b1);
         begin @(negedge clk); wr(2, 0); end
      join
      repeat (40) @(negedge clk);
      expect_frame("R7");
      fill(62); run_frame(2, "R7");

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule